// File: doc/BRIEF.md
# Parallel-to-Serial Interrupt Serializer

This block turns eleven active-high parallel interrupt request lines into slot activity on a single shared open-drain serial interrupt line. It acts as a secondary agent: a host controller opens each frame with a start pulse and closes it with a stop pulse. The block counts the 3-clock slots between the two and acts only in the slots that belong to its own interrupt numbers. The implemented numbers are 3, 4, 5, 6, 7, 9, 10, 11, 12, 14 and 15. The remaining numbers (0, 1, 2, 8 and 13) have no input, and their slots stay untouched.

Two small mask registers, written and read through a simple configuration port, can silence any implemented interrupt. The length of the stop pulse chooses between two modes. In continuous mode the block waits for the host to start every frame. In quiet mode the block may open a frame itself when an enabled request changes. Everything runs on the rising edge of the PCI clock and is reset by the active-low PCI reset. Before use, the request inputs pass through a two-stage synchroniser.

Top module: `sirq_serializer`

## Requirements
- R1: After reset both mask registers read 00h, the serial line is not driven, and the block is in continuous mode, so a request change does not start a frame.
- R2: Mask register at cfg_addr=0 holds disables for interrupts 3, 4, 5, 6, 7, 9, 10 and 11 on bits 0 to 7 in that order. A 1 disables the interrupt, and the value written reads back unchanged.
- R3: Mask register at cfg_addr=1 holds disables for interrupts 12, 14 and 15 on bits 0, 1 and 2. A 1 disables the interrupt, and bits 7 to 3 always read 0.
- R4: A start pulse is accepted only when the line is sampled low on 4 to 8 consecutive clocks. A shorter or longer low run opens no frame.
- R5: After an accepted start, the clock in which the line is first sampled high is followed by one turn-around clock. The sample phase of slot 0 is the clock after that, and slot N starts 3N clocks after slot 0. The frame holds 16 slots.
- R6: In its slot, an enabled request that is inactive (0) makes the block drive low in the sample phase, drive high in the recovery phase, and release the line in the turn-around phase.
- R7: In its slot, an enabled request that is active (1) leaves the line released for all three phases.
- R8: A disabled interrupt, or a slot with no input (0, 1, 2, 8, 13, and any slot past 15), is never driven.
- R9: A stop pulse of exactly 2 low clocks selects quiet mode. A stop pulse of exactly 3 low clocks selects continuous mode.
- R10: In quiet mode, when an enabled request differs from the value reported for it in the last frame, the block drives the line low for exactly one clock while idle. Because of the two-stage synchroniser, this happens in the third clock after the input changes. The host then completes the start pulse.
- R11: In continuous mode a request change never makes the block drive. In quiet mode a change on a disabled request never makes the block drive.
- R12: Outside the slots of a frame, and apart from the one-clock quiet-mode start of R10, the line is never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock, rising edge |
| rst_n | input | 1 | Active-low PCI reset |
| irq_lines | input | 11 | Active-high requests; bit 0..10 = interrupt 3,4,5,6,7,9,10,11,12,14,15 |
| cfg_wr | input | 1 | Write strobe for the mask register selected by cfg_addr |
| cfg_addr | input | 1 | 0 selects the low mask register, 1 selects the high mask register |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected mask register (combinational) |
| sirq_i | input | 1 | Sampled level of the shared serial interrupt line |
| sirq_o | output | 1 | Level driven on the line while sirq_oe is high |
| sirq_oe | output | 1 | Output enable; low releases the line to the pull-up |

## Verification
A slot counter that is off by one shows up within one frame: the low pulses land in the slots of neighbouring interrupt numbers, or overlap the host's stop pulse. A wrong mask decode or a wrong bit order shows up in the first frame as a driven slot that should stay released, or the reverse. A wrong mode flag shows up within three clocks of the next request change, as a missing or an unexpected one-clock low. A start-length window that is off by one makes a 3-clock or 9-clock pulse open a frame, and the slot times that follow then show the driving.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  localparam int NLINE = 11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KICK,
    ST_START,
    ST_TURN,
    ST_SLOT,
    ST_STOPW,
    ST_STOP
  } sirq_state_e;

  // interrupt number carried by parallel line i
  function automatic int line_irq(input int i);
    if (i < 5)       return i + 3;
    else if (i < 8)  return i + 4;
    else if (i == 8) return 12;
    else             return i + 5;
  endfunction

  // a slot is pulled low when enabled and the request is inactive
  function automatic logic slot_pull(input logic en, input logic req);
    return en & ~req;
  endfunction

  // low-run length check for a start pulse
  function automatic logic run_ok(input int cnt, input int lo, input int hi);
    return (cnt >= lo) && (cnt <= hi);
  endfunction

endpackage

// File: rtl/sirq_sync.sv
module sirq_sync #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sirq_cfg.sv
module sirq_cfg #(
  parameter int LO_W = 8,
  parameter int HI_W = 3,
  parameter int DW   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic                 addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  output logic [LO_W+HI_W-1:0] line_dis
);
  logic [LO_W-1:0] mask_lo;
  logic [HI_W-1:0] mask_hi;
  logic            unused_wbits;

  assign unused_wbits = ^wdata[DW-1:HI_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_lo <= '0;
      mask_hi <= '0;
    end else if (wr) begin
      if (!addr) mask_lo <= wdata[LO_W-1:0];
      else       mask_hi <= wdata[HI_W-1:0];
    end
  end

  assign rdata    = addr ? {{(DW-HI_W){1'b0}}, mask_hi} : mask_lo;
  assign line_dis = {mask_hi, mask_lo};
endmodule

// File: rtl/sirq_frame.sv
module sirq_frame
  import sirq_pkg::*;
#(
  parameter int NSLOT     = 16,
  parameter int SW        = $clog2(NSLOT),
  parameter int START_MIN = 4,
  parameter int START_MAX = 8,
  parameter int CNT_W     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_i,
  input  logic          kick_req,
  output sirq_state_e   st,
  output logic [SW-1:0] slot,
  output logic [1:0]    ph,
  output logic          quiet
);
  localparam logic [SW-1:0]    LAST_SLOT = SW'(NSLOT - 1);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] STOP_QT   = CNT_W'(2);
  localparam logic [CNT_W-1:0] STOP_CT   = CNT_W'(3);

  logic [CNT_W-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      slot    <= '0;
      ph      <= '0;
      quiet   <= 1'b0;
      low_cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (quiet && kick_req && line_i) begin
            st <= ST_KICK;
          end else if (!line_i) begin
            st      <= ST_START;
            low_cnt <= CNT_ONE;
          end
        end
        ST_KICK: begin
          if (!line_i) begin
            st      <= ST_START;
            low_cnt <= CNT_ONE;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_START: begin
          if (!line_i) begin
            if (low_cnt != '1) low_cnt <= low_cnt + CNT_ONE;
          end else if (run_ok(int'(low_cnt), START_MIN, START_MAX)) begin
            st <= ST_TURN;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_TURN: begin
          st   <= ST_SLOT;
          slot <= '0;
          ph   <= 2'd0;
        end
        ST_SLOT: begin
          if (ph != 2'd2) begin
            ph <= ph + 2'd1;
          end else begin
            ph <= 2'd0;
            if (slot == LAST_SLOT) st <= ST_STOPW;
            else                   slot <= slot + 1'b1;
          end
        end
        ST_STOPW: begin
          if (!line_i) begin
            st      <= ST_STOP;
            low_cnt <= CNT_ONE;
          end
        end
        ST_STOP: begin
          if (!line_i) begin
            if (low_cnt != '1) low_cnt <= low_cnt + CNT_ONE;
          end else begin
            if (low_cnt == STOP_QT)      quiet <= 1'b1;
            else if (low_cnt == STOP_CT) quiet <= 1'b0;
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sirq_serializer.sv
module sirq_serializer
  import sirq_pkg::*;
#(
  parameter int NSLOT     = 16,
  parameter int START_MIN = 4,
  parameter int START_MAX = 8,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLINE-1:0] irq_lines,
  input  logic             cfg_wr,
  input  logic             cfg_addr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic             sirq_i,
  output logic             sirq_o,
  output logic             sirq_oe
);
  localparam int SW = $clog2(NSLOT);

  logic [NLINE-1:0] irq_s;
  logic [NLINE-1:0] line_dis;
  logic [NLINE-1:0] last_rep;
  logic [NSLOT-1:0] slot_en;
  logic [NSLOT-1:0] slot_req;
  sirq_state_e      st;
  logic [SW-1:0]    slot;
  logic [1:0]       ph;
  logic             quiet;
  logic             kick_req;
  logic             drove_r;

  // named events for the checker
  logic in_slot;
  logic kick_now;
  logic slot_en_cur;
  logic pull_now;

  sirq_sync #(.W(NLINE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_lines), .q(irq_s)
  );

  sirq_cfg #(.LO_W(8), .HI_W(3), .DW(8)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .line_dis(line_dis)
  );

  sirq_frame #(
    .NSLOT(NSLOT), .SW(SW), .START_MIN(START_MIN),
    .START_MAX(START_MAX), .CNT_W(CNT_W)
  ) u_frame (
    .clk(clk), .rst_n(rst_n), .line_i(sirq_i), .kick_req(kick_req),
    .st(st), .slot(slot), .ph(ph), .quiet(quiet)
  );

  // scatter the sparse line set onto slot numbers
  always_comb begin
    slot_en  = '0;
    slot_req = '0;
    for (int i = 0; i < NLINE; i++) begin
      slot_en[line_irq(i)]  = ~line_dis[i];
      slot_req[line_irq(i)] = irq_s[i];
    end
  end

  assign in_slot     = (st == ST_SLOT);
  assign kick_now    = (st == ST_KICK);
  assign slot_en_cur = slot_en[slot];
  assign pull_now    = in_slot && (ph == 2'd0) && slot_pull(slot_en_cur, slot_req[slot]);
  assign kick_req    = |((irq_s ^ last_rep) & ~line_dis);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drove_r  <= 1'b0;
      last_rep <= '0;
    end else begin
      if (in_slot && ph == 2'd0) drove_r <= pull_now;
      for (int i = 0; i < NLINE; i++) begin
        if (in_slot && ph == 2'd0 && slot == SW'(line_irq(i)))
          last_rep[i] <= irq_s[i];
      end
    end
  end

  assign sirq_oe = kick_now || pull_now || (in_slot && ph == 2'd1 && drove_r);
  assign sirq_o  = in_slot && (ph == 2'd1);
endmodule

// File: rtl/sirq_chk.sv
module sirq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sirq_oe,
  input logic       sirq_o,
  input logic       in_slot,
  input logic       kick_now,
  input logic [1:0] ph,
  input logic       slot_en_cur,
  input logic       cfg_addr,
  input logic [7:0] cfg_rdata
);
  assert_no_drive_outside_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_slot && !kick_now) |-> !sirq_oe);

  assert_recovery_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_slot && sirq_oe && !sirq_o) |=> (sirq_oe && sirq_o));

  assert_high_only_after_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sirq_oe && sirq_o) |-> $past(sirq_oe && !sirq_o));

  assert_masked_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_slot && ph == 2'd0 && sirq_oe) |-> slot_en_cur);

  assert_turnaround_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_slot && ph == 2'd2) |-> !sirq_oe);

  assert_kick_one_clock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    kick_now |=> !kick_now);

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_addr |-> (cfg_rdata[7:3] == 5'd0));
endmodule

bind sirq_serializer sirq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sirq_oe(sirq_oe), .sirq_o(sirq_o),
  .in_slot(in_slot), .kick_now(kick_now), .ph(ph),
  .slot_en_cur(slot_en_cur), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata)
);

// File: tb/sim_sirq_serializer.sv
`timescale 1ns/1ps
module sim_sirq_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] irq_lines = '0;
  logic        cfg_wr = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        sirq_o, sirq_oe;
  logic        host_low = 1'b0;
  wire         sirq_i = !(host_low || (sirq_oe && !sirq_o));

  sirq_serializer u0 (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .sirq_i(sirq_i), .sirq_o(sirq_o), .sirq_oe(sirq_oe)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    bit    oe;
    bit    o;
    string tag;
  } item_t;
  item_t exp_q[$];
  bit    mon_busy = 1'b0;

  // bench model
  int          NUM [11] = '{3, 4, 5, 6, 7, 9, 10, 11, 12, 14, 15};
  logic [10:0] irq_v = '0;
  logic [7:0]  mlo = '0;
  logic [2:0]  mhi = '0;

  function automatic bit dis(int i);
    return (i < 8) ? mlo[i] : mhi[i-8];
  endfunction

  function automatic bit exp_pull(int s);
    for (int i = 0; i < 11; i++)
      if (NUM[i] == s) return !dis(i) && !irq_v[i];
    return 1'b0;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: pops expected items and compares at their cycle
  initial begin
    forever begin
      item_t it;
      wait (exp_q.size() > 0);
      mon_busy = 1'b1;
      it = exp_q.pop_front();
      while (cyc < it.at) @(negedge clk);
      if (cyc != it.at) begin
        check(1'b0, {it.tag, " missed sample"}, cyc, it.at);
      end else begin
        check(sirq_oe == it.oe, {it.tag, " oe"}, int'(sirq_oe), int'(it.oe));
        if (it.oe) check(sirq_o == it.o, {it.tag, " level"}, int'(sirq_o), int'(it.o));
      end
      mon_busy = 1'b0;
    end
  end

  task automatic push(int at, bit oe, bit o, string tag);
    item_t it;
    it.at = at; it.oe = oe; it.o = o; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic drain();
    wait (exp_q.size() == 0 && !mon_busy);
    @(negedge clk);
  endtask

  task automatic cfg_write(bit a, logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (!a) mlo = d; else mhi = d[2:0];
  endtask

  task automatic cfg_check(bit a, logic [7:0] e, string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(cfg_rdata == e, tag, int'(cfg_rdata), int'(e));
  endtask

  task automatic idle_window(int n, string tag);
    for (int k = 1; k <= n; k++) push(cyc + k, 1'b0, 1'b0, tag);
    drain();
  endtask

  // host start pulse of L clocks, slot expectations, then stop pulse
  task automatic run_frame(int L, int stop_len, string tag);
    int base;
    bit acc;
    acc = (L >= 4) && (L <= 8);
    host_low = 1'b1;
    repeat (L) @(negedge clk);
    host_low = 1'b0;
    base = cyc + 2;
    for (int s = 0; s < 16; s++) begin
      bit p;
      p = acc && exp_pull(s);
      push(base + 3*s,     p, 1'b0, $sformatf("R5 R6 R7 R8 %s slot %0d sample", tag, s));
      push(base + 3*s + 1, p, 1'b1, $sformatf("R6 %s slot %0d recovery", tag, s));
      push(base + 3*s + 2, 1'b0, 1'b0, $sformatf("R6 %s slot %0d turn", tag, s));
    end
    while (cyc < base + 48) @(negedge clk);
    if (acc) begin
      host_low = 1'b1;
      repeat (stop_len) @(negedge clk);
      host_low = 1'b0;
    end
    drain();
    repeat (2) @(negedge clk);
  endtask

  task automatic set_irq(logic [10:0] v);
    @(negedge clk);
    irq_lines = v;
    irq_v = v;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(sirq_oe == 1'b0, "R1 line released after reset", int'(sirq_oe), 0);
    cfg_check(1'b0, 8'h00, "R1 low mask reset");
    cfg_check(1'b1, 8'h00, "R1 high mask reset");
    // R1: continuous mode after reset, a change does not start a frame
    set_irq(11'h001);
    idle_window(8, "R1 no start in continuous mode");
    set_irq(11'h000);
    repeat (4) @(negedge clk);

    // R2, R3: register access
    cfg_write(1'b0, 8'hA5);
    cfg_check(1'b0, 8'hA5, "R2 low mask readback");
    cfg_write(1'b1, 8'hFF);
    cfg_check(1'b1, 8'h07, "R3 high mask reserved bits zero");
    cfg_write(1'b0, 8'h00);
    cfg_write(1'b1, 8'h00);

    // frame A: all inactive, all enabled, shortest start, continuous stop
    run_frame(4, 3, "A");

    // frame B: mixed requests with masks, longest start, quiet stop (R9)
    cfg_write(1'b0, 8'h81);
    cfg_write(1'b1, 8'h04);
    set_irq(11'b101_0101_0101);
    repeat (4) @(negedge clk);
    run_frame(8, 2, "B");

    // R11: change of a disabled line in quiet mode
    set_irq(irq_v ^ 11'h001);
    idle_window(8, "R11 disabled change no drive");

    // R4: rejected start pulses
    run_frame(3, 0, "R4 short");
    run_frame(9, 0, "R4 long");

    // R10: enabled change in quiet mode starts a frame
    begin
      int t;
      set_irq(irq_v ^ 11'h002);
      t = cyc;
      push(t + 1, 1'b0, 1'b0, "R12 before start");
      push(t + 2, 1'b0, 1'b0, "R10 synchroniser delay");
      push(t + 3, 1'b1, 1'b0, "R10 quiet start low");
      while (cyc < t + 3) @(negedge clk);
      run_frame(4, 3, "C");
    end

    // R11 / R9: back in continuous mode, enabled change does nothing
    set_irq(irq_v ^ 11'h004);
    idle_window(8, "R11 R9 continuous ignores change");

    // frame D: all active, nothing driven
    cfg_write(1'b0, 8'h00);
    cfg_write(1'b1, 8'h00);
    set_irq(11'h7FF);
    repeat (4) @(negedge clk);
    run_frame(6, 3, "D");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule